// File: doc/BRIEF.md
# Cascadable Up/Down Counter Built from One-Bit Slices

This block is an N-bit binary counter made from one-bit slices that are all the same. Each slice holds one D flip-flop. It receives a data bit and the shared control lines. It also receives a toggle-enable from the slice below and passes a toggle-enable to the slice above. A slice flips only when every slice beneath it sits at its terminal value for the selected direction: all ones when counting up, all zeros when counting down. The toggle-enable that leaves the top slice is brought out as a ripple carry. The carry-in can enable the whole counter, so several counters chain into a wider one.

Three operations are available. Load copies the data word into the register. Count moves the register up or down by one, and the direction can change from one clock to the next. Hold leaves every bit untouched. Load takes precedence over counting.

A build parameter picks how load is made. In the default build, load and reset act at the clock edge. In the other build, each flip-flop is preset or cleared directly from its data bit while load is high, with no clock needed. Reset reaches the register through that same preset/clear path.

Top module: `updown_slice_counter`

## Requirements
- R1: In the default (clocked-load) build, `rst`=1 makes `q` all zeros after the next rising edge, whatever the values of `ld`, `en` and `cin`.
- R2: With `ld`=0, `q` keeps its value across a rising edge whenever `en`=0 or `cin`=0.
- R3: With `ld`=1, `q` takes the value of `din` at the next rising edge, for either value of `en`.
- R4: With `ld`=0, `en`=1, `cin`=1 and `down`=0, `q` increases by one at each edge. The value 2^N-1 wraps to 0.
- R5: With `ld`=0, `en`=1, `cin`=1 and `down`=1, `q` decreases by one at each edge. The value 0 wraps to 2^N-1.
- R6: The direction is taken from `down` at each edge on its own, so alternating `down` on consecutive clocks alternates increments and decrements.
- R7: `rco` is combinational and equals `en` AND `cin` AND (`q` all ones when `down`=0, or `q` all zeros when `down`=1). It does not depend on `ld`.
- R8: In the preset/clear-load build, `ld`=1 forces `q` to `din` without a clock edge, and `q` follows changes of `din` while `ld` stays high. `rst`=1 clears `q` at once. After `ld` falls, counting resumes at the next edge from the loaded value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Active-high reset (clocked in the default build, immediate in the preset/clear build) |
| ld | input | 1 | Parallel load command, has priority over counting |
| en | input | 1 | Count enable. When 0 and `ld`=0, the counter holds |
| cin | input | 1 | Cascade enable from a lower counter stage |
| down | input | 1 | Direction: 0 counts up, 1 counts down |
| din | input | WIDTH | Parallel load data |
| q | output | WIDTH | Counter value |
| rco | output | 1 | Ripple carry/borrow enable for the next stage |

## Verification
In the default build, the bound checker watches the clocked operations on every edge: reset, load priority, hold, increment and decrement with wrap. It also checks at every cycle that the ripple output matches the terminal condition. Several behaviours need set-up scenarios in the bench. These are the direction alternating on back-to-back clocks and the exact wrap values at both ends. They also include the preset/clear build, where `q` must follow `din` between clock edges while load is held and must clear at once on reset.

// File: rtl/cnt_pkg.sv
package cnt_pkg;

    typedef enum logic {
        DIR_UP   = 1'b0,
        DIR_DOWN = 1'b1
    } dir_e;

    typedef struct packed {
        logic ld;
        logic cnt_en;
        dir_e dir;
    } slice_ctrl_t;

    // Enable handed to the next slice: this slice is at its terminal value
    function automatic logic pass_enable(input logic t_in, input logic q, input dir_e dir);
        return t_in & ((dir == DIR_DOWN) ? ~q : q);
    endfunction

    // Next value of a slice with a clocked load
    function automatic logic next_bit(input logic q, input logic d, input logic t_in,
                                      input logic ld);
        return ld ? d : (q ^ t_in);
    endfunction

endpackage

// File: rtl/cnt_bit_slice.sv
module cnt_bit_slice
    import cnt_pkg::*;
#(
    parameter bit ASYNC_LOAD = 1'b0
) (
    input  logic        clk,
    input  logic        rst,
    input  slice_ctrl_t ctrl,
    input  logic        d,
    input  logic        t_in,
    output logic        q,
    output logic        t_out
);

    logic q_r;

    generate
        if (ASYNC_LOAD) begin : g_async
            logic pre_n_act;
            logic clr_act;
            // Data steers the preset/clear overrides while load is high
            assign clr_act   = rst | (ctrl.ld & ~d);
            assign pre_n_act = ~rst & ctrl.ld & d;

            always_ff @(posedge clk or posedge clr_act or posedge pre_n_act) begin
                if (clr_act) begin
                    q_r <= 1'b0;
                end else if (pre_n_act) begin
                    q_r <= 1'b1;
                end else begin
                    q_r <= q_r ^ t_in;
                end
            end
        end else begin : g_sync
            always_ff @(posedge clk) begin
                if (rst) begin
                    q_r <= 1'b0;
                end else begin
                    q_r <= next_bit(q_r, d, t_in, ctrl.ld);
                end
            end
        end
    endgenerate

    assign q     = q_r;
    assign t_out = pass_enable(t_in, q_r, ctrl.dir);

endmodule

// File: rtl/cnt_slice_chain.sv
module cnt_slice_chain
    import cnt_pkg::*;
#(
    parameter int unsigned WIDTH      = 8,
    parameter bit          ASYNC_LOAD = 1'b0
) (
    input  logic             clk,
    input  logic             rst,
    input  slice_ctrl_t      ctrl,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] q,
    output logic             t_top
);

    localparam int unsigned NLINK = WIDTH + 1;

    logic [NLINK-1:0] tlink;

    assign tlink[0] = ctrl.cnt_en;

    for (genvar j = 0; j < WIDTH; j++) begin : g_slice
        cnt_bit_slice #(
            .ASYNC_LOAD(ASYNC_LOAD)
        ) i_slice (
            .clk  (clk),
            .rst  (rst),
            .ctrl (ctrl),
            .d    (din[j]),
            .t_in (tlink[j]),
            .q    (q[j]),
            .t_out(tlink[j+1])
        );
    end

    assign t_top = tlink[NLINK-1];

endmodule

// File: rtl/updown_slice_counter.sv
module updown_slice_counter
    import cnt_pkg::*;
#(
    parameter int unsigned WIDTH      = 8,
    parameter bit          ASYNC_LOAD = 1'b0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ld,
    input  logic             en,
    input  logic             cin,
    input  logic             down,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] q,
    output logic             rco
);

    slice_ctrl_t ctrl;

    always_comb begin
        ctrl.ld     = ld;
        ctrl.cnt_en = en & cin;
        ctrl.dir    = down ? DIR_DOWN : DIR_UP;
    end

    cnt_slice_chain #(
        .WIDTH     (WIDTH),
        .ASYNC_LOAD(ASYNC_LOAD)
    ) i_chain (
        .clk  (clk),
        .rst  (rst),
        .ctrl (ctrl),
        .din  (din),
        .q    (q),
        .t_top(rco)
    );

endmodule

// File: rtl/updown_slice_counter_chk.sv
module updown_slice_counter_chk #(
    parameter int unsigned WIDTH      = 8,
    parameter bit          ASYNC_LOAD = 1'b0
) (
    input logic             clk,
    input logic             rst,
    input logic             ld,
    input logic             en,
    input logic             cin,
    input logic             down,
    input logic [WIDTH-1:0] din,
    input logic [WIDTH-1:0] q,
    input logic             rco
);

    // R7: ripple output tracks the terminal condition
    assert_rco_terminal_R7: assert property (@(posedge clk) disable iff (rst)
        rco == (en && cin && (down ? (q == '0) : (q == '1))));

    generate
        if (!ASYNC_LOAD) begin : g_clocked
            assert_reset_clears_R1: assert property (@(posedge clk)
                rst |=> (q == '0));

            assert_true_hold_R2: assert property (@(posedge clk) disable iff (rst)
                (!ld && !(en && cin)) |=> $stable(q));

            assert_load_priority_R3: assert property (@(posedge clk) disable iff (rst)
                ld |=> (q == $past(din)));

            assert_count_up_R4: assert property (@(posedge clk) disable iff (rst)
                (!ld && en && cin && !down) |=> (q == WIDTH'($past(q) + 1'b1)));

            assert_count_down_R5: assert property (@(posedge clk) disable iff (rst)
                (!ld && en && cin && down) |=> (q == WIDTH'($past(q) - 1'b1)));
        end
    endgenerate

endmodule

bind updown_slice_counter updown_slice_counter_chk #(
    .WIDTH     (WIDTH),
    .ASYNC_LOAD(ASYNC_LOAD)
) i_chk (
    .clk (clk),
    .rst (rst),
    .ld  (ld),
    .en  (en),
    .cin (cin),
    .down(down),
    .din (din),
    .q   (q),
    .rco (rco)
);

// File: tb/test_updown_slice_counter.sv
`timescale 1ns/1ps
module test_updown_slice_counter;

    localparam int W = 8;
    localparam real HALF = 2.5;

    logic clk = 1'b0;
    always #(HALF) clk = ~clk;

    logic         rst = 1'b1, ld = 1'b0, en = 1'b0, cin = 1'b1, down = 1'b0;
    logic [W-1:0] din = '0;
    logic [W-1:0] q;
    logic         rco;

    logic         a_rst = 1'b1, a_ld = 1'b0, a_en = 1'b0;
    logic [W-1:0] a_din = '0;
    logic [W-1:0] a_q;
    logic         a_rco;

    updown_slice_counter #(.WIDTH(W), .ASYNC_LOAD(1'b0)) i_updown_slice_counter (
        .clk(clk), .rst(rst), .ld(ld), .en(en), .cin(cin), .down(down),
        .din(din), .q(q), .rco(rco));

    updown_slice_counter #(.WIDTH(W), .ASYNC_LOAD(1'b1)) i_updown_slice_counter_async (
        .clk(clk), .rst(a_rst), .ld(a_ld), .en(a_en), .cin(1'b1), .down(1'b0),
        .din(a_din), .q(a_q), .rco(a_rco));

    int errors = 0;
    int checks = 0;
    bit done   = 1'b0;

    logic [W-1:0] exp_q[$];
    string        exp_tag[$];
    logic [W-1:0] model = '0;

    task automatic check(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Driver: apply one cycle of stimulus, push the expected result
    task automatic drive(input logic r, input logic l, input logic e, input logic c,
                         input logic dn, input logic [W-1:0] dv, input string tag);
        logic         xr;
        logic [W-1:0] nx;
        @(negedge clk);
        rst = r; ld = l; en = e; cin = c; down = dn; din = dv;
        xr = e & c & (dn ? (model == '0) : (model == '1));
        if      (r)     nx = '0;
        else if (l)     nx = dv;
        else if (e & c) nx = dn ? W'(model - 1'b1) : W'(model + 1'b1);
        else            nx = model;
        exp_q.push_back(nx);
        exp_tag.push_back(tag);
        #1;
        if (!r) check("R7 rco", {{(W-1){1'b0}}, rco}, {{(W-1){1'b0}}, xr});
        model = nx;
    endtask

    // Monitor: compare after each rising edge
    always @(posedge clk) begin
        #1;
        if (exp_q.size() > 0) begin
            logic [W-1:0] e;
            string        t;
            e = exp_q.pop_front();
            t = exp_tag.pop_front();
            check(t, q, e);
        end
    end

    initial begin
        #(200000 * 2 * HALF);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        // R1 reset, including over a pending load
        drive(1, 0, 0, 1, 0, 8'h00, "R1 reset");
        drive(1, 1, 1, 1, 0, 8'h5A, "R1 reset beats load");
        // R3 load with en low and with en high
        drive(0, 1, 0, 1, 0, 8'h37, "R3 load en=0");
        drive(0, 1, 1, 1, 1, 8'hC4, "R3 load en=1");
        // R2 hold: en low, then cin low
        drive(0, 0, 0, 1, 0, 8'hFF, "R2 hold en=0");
        drive(0, 0, 1, 0, 1, 8'h00, "R2 hold cin=0");
        drive(0, 0, 0, 0, 0, 8'h11, "R2 hold both");
        // R4 count up across the top and wrap
        drive(0, 1, 0, 1, 0, 8'hFD, "R3 preload");
        for (int i = 0; i < 4; i++) drive(0, 0, 1, 1, 0, 8'h00, "R4 up wrap");
        // R5 count down across zero
        drive(0, 1, 0, 1, 0, 8'h02, "R3 preload");
        for (int i = 0; i < 4; i++) drive(0, 0, 1, 1, 1, 8'h00, "R5 down wrap");
        // R6 alternate direction every clock
        drive(0, 1, 0, 1, 0, 8'h80, "R3 preload");
        for (int i = 0; i < 6; i++) drive(0, 0, 1, 1, i[0], 8'h00, "R6 alternate");
        drive(0, 0, 1, 1, 0, 8'h00, "R6 up");
        drive(0, 0, 1, 1, 0, 8'h00, "R6 up");
        drive(0, 0, 1, 1, 1, 8'h00, "R6 down");
        // R4 ripple through many bits
        drive(0, 1, 0, 1, 0, 8'h7F, "R3 preload");
        drive(0, 0, 1, 1, 0, 8'h00, "R4 carry ripple");
        drive(0, 0, 0, 1, 0, 8'h00, "R2 hold after ripple");
        @(negedge clk);
        ld = 0; en = 0;

        // R8 preset/clear-load build
        @(negedge clk);
        #1; check("R8 immediate reset", a_q, 8'h00);
        a_rst = 1'b0;
        @(negedge clk);
        a_ld = 1'b1; a_din = 8'hA5;
        #1; check("R8 load without edge", a_q, 8'hA5);
        a_din = 8'h3C;
        #1; check("R8 follows din", a_q, 8'h3C);
        @(posedge clk); #1;
        check("R8 edge ignored under load", a_q, 8'h3C);
        @(negedge clk);
        a_ld = 1'b0; a_en = 1'b1;
        @(posedge clk); #1;
        check("R8 counts after load", a_q, 8'h3D);
        @(negedge clk);
        a_en = 1'b0;
        a_rst = 1'b1;
        #1; check("R8 reset clears at once", a_q, 8'h00);
        a_rst = 1'b0;

        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule